// File: doc/BRIEF.md
# Halfword-Addressed FIFO Read Window

This block holds a small internal FIFO and exposes its head entry through a read-only window on a 16-bit memory-style bus. A producer pushes entries on one side. On the other side, a processor or a DMA engine reads a fixed address again and again, and each read yields the next value. The reader never has to step its source address. That suits an engine that can only increment, because it can run with a source stride of zero.

In the default wide configuration each entry is 32 bits and sits behind two halfword addresses. The lower address shows the least-significant half of the head entry. The address two bytes above it shows the most-significant half. Only a read of the upper half retires the entry, so a reader that fetches the lower half first and then the upper half walks through the stream in order. In the narrow configuration each entry is 16 bits, and one address returns the head and retires it on every read.

Each read result is registered and appears one clock after the address is sampled. The window base is a parameter and must sit on a 32-byte boundary. Empty reads, pushes into a full FIFO and reads that miss the window are handled as described below.

Top module: `hfw_fifo_window`

## Requirements
- R1: In wide mode (FIFO_WIDE=1), a read of address BASE_ADDR returns bits [15:0] of the head entry and never retires an entry.
- R2: In wide mode, a read of address BASE_ADDR+2 returns bits [31:16] of the head entry and retires that entry on the same clock edge.
- R3: In narrow mode (FIFO_WIDE=0), a read of address BASE_ADDR returns the whole 16-bit head entry and retires it, so repeated reads of that one address return successive entries.
- R4: The window occupies BASE_ADDR only (narrow mode) or BASE_ADDR and BASE_ADDR+2 only (wide mode). A BASE_ADDR whose low five bits are not zero is rejected at elaboration.
- R5: Any window read while the FIFO is empty returns zero and retires nothing. A read of the retiring address while empty also sets the `underflow` flag, which stays set until reset.
- R6: A push while `full` is high is dropped, even if a read retires an entry on the same edge, and it sets the `overflow` flag, which stays set until reset.
- R7: A read of any address outside the window returns zero and changes no FIFO state.
- R8: `rd_data` is updated on the clock edge that samples `rd_en` high, and a retire takes effect on that same edge. While `rd_en` is low, `rd_data` holds its value.
- R9: After reset, `empty` is 1, `full` is 0, both flags are 0 and `rd_data` is 0.
- R10: Entries leave in the order they were pushed. `full` is high exactly when DEPTH entries are held, and `empty` is high exactly when none are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_valid | input | 1 | Push request for `push_data` |
| push_data | input | ENTRY_W | Entry to enqueue (32 bits in wide mode, 16 in narrow mode) |
| full | output | 1 | FIFO holds DEPTH entries |
| empty | output | 1 | FIFO holds no entries |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Bus byte address |
| rd_data | output | 16 | Registered read data |
| overflow | output | 1 | Sticky: a push was dropped |
| underflow | output | 1 | Sticky: retiring read while empty |

## Verification
The bench builds two copies of the block side by side. One is wide, with DEPTH 4 and the base at 0x140. The other is narrow, with DEPTH 4 and the base at 0x1E0. The shallow depth lets both directed and random traffic reach the full and empty boundaries often, so dropped pushes, empty retiring reads and a push on the same edge as a retire all occur many times. Running both widths covers both decode variants, including the narrow copy's treatment of BASE_ADDR+2 as an address outside the window.

// File: rtl/hfw_pkg.sv
// Package: shared definitions for the halfword FIFO read window.
// Assumes a fixed 16-bit bus data path.
package hfw_pkg;
    localparam int HW_BITS = 16;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2
    } win_sel_t;
endpackage

// File: rtl/hfw_fifo_store.sv
// Module: FIFO storage with push and retire ports and a sticky overflow flag.
// Assumes DEPTH is a power of two and at least 2. The caller gates
// retire with !empty. A push while full is dropped.
module hfw_fifo_store #(
    parameter int ENTRY_W = 32,
    parameter int DEPTH   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_valid,
    input  logic [ENTRY_W-1:0] push_data,
    input  logic               retire,
    output logic [ENTRY_W-1:0] head,
    output logic               empty,
    output logic               full,
    output logic               overflow
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [ENTRY_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CNT_W-1:0]   count;
    logic               push_ok;

    generate
        if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
            $error("hfw_fifo_store: DEPTH must be a power of two of at least 2");
        end
    endgenerate

    assign push_ok = push_valid && !full;
    assign empty   = (count == '0);
    assign full    = (count == CNT_FULL);
    assign head    = slots[rd_ptr];

    // Write an accepted entry into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) slots[wr_ptr] <= push_data;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (retire)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, retire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Record a dropped push until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                  overflow <= 1'b0;
        else if (push_valid && full) overflow <= 1'b1;
    end
endmodule

// File: rtl/hfw_addr_decode.sv
// Module: maps a bus byte address to a window slot.
// Wide mode uses two halfword slots (lower, upper). Narrow mode has one
// slot, and that slot retires the head entry.
module hfw_addr_decode
    import hfw_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter bit              FIFO_WIDE = 1'b1
) (
    input  logic [ADDR_W-1:0] rd_addr,
    output win_sel_t          sel
);
    localparam logic [ADDR_W-1:0] UPPER_ADDR = BASE_ADDR + ADDR_W'(2);

    generate
        if (FIFO_WIDE) begin : g_wide
            // Two halfword slots: lower half at base, upper half above it.
            always_comb begin
                if (rd_addr == BASE_ADDR)       sel = SEL_LO;
                else if (rd_addr == UPPER_ADDR) sel = SEL_HI;
                else                            sel = SEL_NONE;
            end
        end else begin : g_narrow
            // One slot that retires on every read.
            always_comb begin
                sel = (rd_addr == BASE_ADDR) ? SEL_HI : SEL_NONE;
            end
        end
    endgenerate
endmodule

// File: rtl/hfw_read_port.sv
// Module: registered read path, retire request and sticky underflow flag.
// Assumes the upper slice of the head entry is the retiring half. In
// narrow mode that slice is the whole entry.
module hfw_read_port
    import hfw_pkg::*;
#(
    parameter int ENTRY_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  win_sel_t           sel,
    input  logic [ENTRY_W-1:0] head,
    input  logic               empty,
    output logic               retire,
    output logic [HW_BITS-1:0] rd_data,
    output logic               underflow
);
    logic [HW_BITS-1:0] word;

    // Select the halfword to return; empty FIFO or a miss yields zero.
    always_comb begin
        word = '0;
        if (!empty) begin
            case (sel)
                SEL_LO:  word = head[HW_BITS-1:0];
                SEL_HI:  word = head[ENTRY_W-1 -: HW_BITS];
                default: word = '0;
            endcase
        end
    end

    assign retire = rd_en && (sel == SEL_HI) && !empty;

    // Capture read data on a sampled read strobe, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= word;
    end

    // Record a retiring read that found the FIFO empty.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  underflow <= 1'b0;
        else if (rd_en && (sel == SEL_HI) && empty)  underflow <= 1'b1;
    end
endmodule

// File: rtl/hfw_fifo_window.sv
// Module: top of the halfword-addressed FIFO read window.
// Assumes a single-cycle registered read bus. The bus has no write path.
// BASE_ADDR must be 32-byte aligned.
module hfw_fifo_window
    import hfw_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0140,
    parameter bit                FIFO_WIDE = 1'b1,
    parameter int                DEPTH     = 4,
    localparam int               ENTRY_W   = FIFO_WIDE ? 2 * HW_BITS : HW_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_valid,
    input  logic [ENTRY_W-1:0] push_data,
    output logic               full,
    output logic               empty,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [HW_BITS-1:0] rd_data,
    output logic               overflow,
    output logic               underflow
);
    win_sel_t           sel;
    logic               retire;
    logic [ENTRY_W-1:0] head;

    generate
        if (BASE_ADDR[4:0] != 5'd0) begin : g_bad_base
            $error("hfw_fifo_window: BASE_ADDR must be 32-byte aligned");
        end
    endgenerate

    hfw_addr_decode #(
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR),
        .FIFO_WIDE(FIFO_WIDE)
    ) u_decode (
        .rd_addr(rd_addr),
        .sel    (sel)
    );

    hfw_fifo_store #(
        .ENTRY_W(ENTRY_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_valid(push_valid),
        .push_data (push_data),
        .retire    (retire),
        .head      (head),
        .empty     (empty),
        .full      (full),
        .overflow  (overflow)
    );

    hfw_read_port #(
        .ENTRY_W(ENTRY_W)
    ) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .sel      (sel),
        .head     (head),
        .empty    (empty),
        .retire   (retire),
        .rd_data  (rd_data),
        .underflow(underflow)
    );
endmodule

// File: rtl/hfw_window_checker.sv
// Module: port-level properties of the FIFO read window, bound to the top.
// Watches only top-level ports.
module hfw_window_checker #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter bit                FIFO_WIDE = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_valid,
    input logic              full,
    input logic              empty,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [15:0]       rd_data,
    input logic              overflow,
    input logic              underflow
);
    localparam logic [ADDR_W-1:0] RET_ADDR = FIFO_WIDE ? BASE_ADDR + ADDR_W'(2) : BASE_ADDR;

    logic in_win;
    assign in_win = (rd_addr == BASE_ADDR) || (rd_addr == RET_ADDR);

    a_r7_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !in_win |=> rd_data == 16'h0);

    a_r7_outside_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !in_win && !push_valid |=> $stable(empty) && $stable(full));

    a_r1_lower_no_retire: assert property (@(posedge clk) disable iff (!rst_n)
        FIFO_WIDE && rd_en && rd_addr == BASE_ADDR && !push_valid |=> $stable(empty) && $stable(full));

    a_r2_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_addr == RET_ADDR && full && !push_valid |=> !full);

    a_r5_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && empty |=> rd_data == 16'h0);

    a_r5_underflow_set: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_addr == RET_ADDR && empty |=> underflow);

    a_r5_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    a_r6_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && full |=> overflow);

    a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    a_r10_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

bind hfw_fifo_window hfw_window_checker #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .FIFO_WIDE(FIFO_WIDE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_valid(push_valid),
    .full      (full),
    .empty     (empty),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .overflow  (overflow),
    .underflow (underflow)
);

// File: tb/hfw_fifo_window_test.sv
// Bench: a wide and a narrow copy of the window, directed corners plus
// seeded random traffic, checked against queue models.
module hfw_fifo_window_test;
    localparam logic [15:0] WB = 16'h0140;
    localparam logic [15:0] NB = 16'h01E0;
    localparam int          DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        w_pv = 0, w_re = 0;
    logic [31:0] w_pd = '0;
    logic [15:0] w_addr = '0;
    logic        w_full, w_empty, w_ovf, w_uf;
    logic [15:0] w_rd;

    logic        n_pv = 0, n_re = 0;
    logic [15:0] n_pd = '0;
    logic [15:0] n_addr = '0;
    logic        n_full, n_empty, n_ovf, n_uf;
    logic [15:0] n_rd;

    hfw_fifo_window #(.ADDR_W(16), .BASE_ADDR(WB), .FIFO_WIDE(1'b1), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .push_valid(w_pv), .push_data(w_pd),
        .full(w_full), .empty(w_empty), .rd_en(w_re), .rd_addr(w_addr),
        .rd_data(w_rd), .overflow(w_ovf), .underflow(w_uf));

    hfw_fifo_window #(.ADDR_W(16), .BASE_ADDR(NB), .FIFO_WIDE(1'b0), .DEPTH(DEPTH)) uut_narrow (
        .clk(clk), .rst_n(rst_n), .push_valid(n_pv), .push_data(n_pd),
        .full(n_full), .empty(n_empty), .rd_en(n_re), .rd_addr(n_addr),
        .rd_data(n_rd), .overflow(n_ovf), .underflow(n_uf));

    int nchk = 0;
    int nerr = 0;
    logic [31:0] qw[$];
    logic [15:0] qn[$];
    logic [15:0] exp_rd[2];
    bit          exp_ovf[2];
    bit          exp_uf[2];

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] read_value(input bit nar, input logic [15:0] addr,
                                               input int sz, input logic [31:0] hd);
        logic [15:0] base = nar ? NB : WB;
        logic [15:0] ret  = nar ? NB : WB + 16'd2;
        if (sz == 0) return 16'h0;
        if (!nar && addr == base) return hd[15:0];
        if (addr == ret) return nar ? hd[15:0] : hd[31:16];
        return 16'h0;
    endfunction

    // One bus cycle on one copy; the other copy idles. Inputs change at negedge.
    task automatic step(input bit nar, input bit pv, input logic [31:0] pd,
                        input bit re, input logic [15:0] addr, input string force_tag);
        int          sz   = nar ? qn.size() : qw.size();
        logic [31:0] hd   = (sz == 0) ? 32'h0 : (nar ? {16'h0, qn[0]} : qw[0]);
        logic [15:0] base = nar ? NB : WB;
        logic [15:0] ret  = nar ? NB : WB + 16'd2;
        string       tag;
        bit          pop;
        int          i = nar ? 1 : 0;
        if (addr == ret)       tag = nar ? "R3" : "R2";
        else if (addr == base) tag = "R1";
        else                   tag = "R7";
        if ((addr == base || addr == ret) && sz == 0) tag = "R5";
        if (!re) tag = "R8";
        if (force_tag != "") tag = force_tag;
        if (re) exp_rd[i] = read_value(nar, addr, sz, hd);
        pop = re && addr == ret && sz > 0;
        if (re && addr == ret && sz == 0) exp_uf[i] = 1'b1;
        if (pv && sz >= DEPTH) exp_ovf[i] = 1'b1;
        if (pop) begin
            if (nar) void'(qn.pop_front()); else void'(qw.pop_front());
        end
        if (pv && sz < DEPTH) begin
            if (nar) qn.push_back(pd[15:0]); else qw.push_back(pd);
        end
        w_pv = !nar && pv; w_pd = pd;       w_re = !nar && re; w_addr = addr;
        n_pv = nar && pv;  n_pd = pd[15:0]; n_re = nar && re;  n_addr = addr;
        @(posedge clk);
        @(negedge clk);
        sz = nar ? qn.size() : qw.size();
        check(tag, "rd_data", nar ? n_rd : w_rd, exp_rd[i]);
        check("R10", "empty", nar ? n_empty : w_empty, sz == 0);
        check("R10", "full", nar ? n_full : w_full, sz == DEPTH);
        check("R6", "overflow", nar ? n_ovf : w_ovf, exp_ovf[i]);
        check("R5", "underflow", nar ? n_uf : w_uf, exp_uf[i]);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=hung expected=done");
        report();
    end

    initial begin
        void'($urandom(32'd2024));
        exp_rd[0] = '0; exp_rd[1] = '0;
        exp_ovf[0] = 0; exp_ovf[1] = 0;
        exp_uf[0] = 0;  exp_uf[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: state right after reset
        check("R9", "rd_data", w_rd, 0);
        check("R9", "empty", w_empty, 1);
        check("R9", "full", w_full, 0);
        check("R9", "overflow", w_ovf, 0);
        check("R9", "underflow", w_uf, 0);
        check("R9", "narrow empty", n_empty, 1);
        check("R9", "narrow rd_data", n_rd, 0);

        // Wide copy: empty lower read, then empty retiring read (R5)
        step(0, 0, 0, 1, WB, "R5");
        step(0, 0, 0, 1, WB + 16'd2, "R5");
        // Fill to full (R10), then a dropped push (R6)
        for (int k = 0; k < DEPTH; k++) step(0, 1, 32'hA000_0001 + 32'(k) * 32'h0101_0101, 0, 0, "");
        step(0, 1, 32'hDEAD_BEEF, 0, 0, "R6");
        // Dropped push on the same edge as a retire (R6)
        step(0, 1, 32'hBAD0_BAD0, 1, WB + 16'd2, "R6");
        // Lower half read twice without retiring (R1)
        step(0, 0, 0, 1, WB, "R1");
        step(0, 0, 0, 1, WB, "R1");
        // Misses around the window (R7, R4 location)
        step(0, 0, 0, 1, WB + 16'd4, "R4");
        step(0, 0, 0, 1, WB - 16'd2, "R7");
        step(0, 0, 0, 1, WB + 16'd1, "R7");
        step(0, 0, 0, 0, WB, "R8");
        // Drain in pairs (R2, R10 ordering)
        for (int k = 0; k < DEPTH; k++) begin
            step(0, 0, 0, 1, WB, "R1");
            step(0, 0, 0, 1, WB + 16'd2, "R2");
        end

        // Narrow copy: single address retires each read (R3)
        for (int k = 0; k < 3; k++) step(1, 1, 32'(16'h5A00 + k), 0, 0, "");
        step(1, 0, 0, 1, NB + 16'd2, "R4");
        for (int k = 0; k < 3; k++) step(1, 0, 0, 1, NB, "R3");
        step(1, 0, 0, 1, NB, "R5");

        // Seeded random traffic on both copies
        for (int k = 0; k < 1500; k++) begin
            bit          nar = $urandom_range(0, 1) == 1;
            bit          pv  = $urandom_range(0, 99) < 45;
            bit          re  = $urandom_range(0, 99) < 60;
            logic [15:0] b   = nar ? NB : WB;
            logic [15:0] a;
            case ($urandom_range(0, 5))
                0, 1:    a = b;
                2, 3:    a = b + 16'd2;
                4:       a = b + 16'd4;
                default: a = 16'($urandom());
            endcase
            step(nar, pv, $urandom(), re, a, "");
        end
        report();
    end
endmodule